// File: doc/BRIEF.md
# SPI Slave Control Port with Input Flow Control

This block is the host-facing serial control port of an embedded processor. An external host acts as SPI master in mode 0: the clock idles low, the host drives MOSI while the clock is low, and both sides sample on the rising edge. The port oversamples the serial clock, chip-select and MOSI in the faster internal clock domain. Edge detection is therefore done entirely with internal-clock logic, which is valid while the serial clock runs at no more than a third of the internal rate.

Every transaction opens with a header byte that holds a 7-bit register address and a direction flag. In a write to the data-port address, the bytes that follow go into an input FIFO, which the processor drains. In a write to any other address, the bytes go into a small register file. In a read, the bytes come from an output FIFO that the processor fills.

Two sideband lines complete the link. An active-low busy line tells the host to pause before the input FIFO overruns. An active-low interrupt line announces pending read data; it is released once a read starts and re-armed only when chip-select rises.

Top module: `spi_ctrl_port`

## Requirements
- R1: The first eight bits after chip-select falls form the header, sampled on serial-clock rising edges and sent MSB first. Bits 7..1 are the address and bit 0 is the direction: 1 means read and 0 means write.
- R2: In a write to address DATA_ADDR (default 0x20), each following 8-bit byte, sent MSB first, is pushed into the input FIFO. The byte at the head of the FIFO is shown on `rx_data` while `rx_valid` is high, and `rx_pop` removes it.
- R3: In a write to any other address, each data byte is stored in register `addr[2:0]`, and the last byte of the transaction is the one that remains. `reg_value` shows the register selected by `reg_sel`. The input FIFO is left untouched.
- R4: In a read, each data byte after the header is the head of the output FIFO, sent MSB first. Each bit changes on `spi_miso` after a serial-clock falling edge, ready for the next rising edge. If the FIFO is empty, the byte is 0x00.
- R5: `busy_n` goes low one internal clock after the input FIFO holds 2 or fewer free entries out of 8. It goes high again one clock after 4 or more entries are free. With exactly 3 free entries it keeps its previous level.
- R6: Data-port bytes that arrive while the input FIFO is full are dropped, and the bytes already in the FIFO are unchanged.
- R7: `irq_n` is low while the output FIFO is non-empty and chip-select is high. It goes high at the first serial-clock falling edge of a read's data phase and stays high until chip-select rises.
- R8: If chip-select rises in the middle of a byte, the partial byte is discarded and the next transaction starts again with a header.
- R9: After reset, `busy_n` and `irq_n` are high, `rx_valid` is low, `spi_miso_oe` is low and all registers read 0. `spi_miso_oe` is high only while the synchronised chip-select is low.
- R10: An output-FIFO byte is removed only at the first rising edge of the data byte that carries it. A byte preloaded on the final falling edge of a transaction stays in the FIFO for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, at least 3x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host (idles low) |
| spi_cs_n | input | 1 | Active-low chip-select from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| busy_n | output | 1 | Low: host must pause data-port writes |
| irq_n | output | 1 | Low: read data pending |
| rx_pop | input | 1 | Processor removes input-FIFO head |
| rx_data | output | 8 | Input-FIFO head byte |
| rx_valid | output | 1 | Input FIFO non-empty |
| tx_push | input | 1 | Processor writes a byte to the output FIFO |
| tx_data | input | 8 | Byte to write to the output FIFO |
| tx_full | output | 1 | Output FIFO full |
| reg_sel | input | 3 | Register file read select |
| reg_value | output | 8 | Selected register contents |

## Verification
A corrupted bit counter or phase register shows up at the ports within one transaction. A data byte appears on `rx_data` shifted or under the wrong address, or a read returns the wrong byte on `spi_miso` at the first sampled bit. Wrong hysteresis state appears on `busy_n` one clock after the byte that crosses a threshold. A mistimed output-FIFO pop shows up as a lost or repeated byte on the next read, and a stale interrupt arm shows up as `irq_n` staying low during a read data phase.

// File: rtl/spi_cp_pkg.sv
package spi_cp_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [1:0] {
        PH_HDR = 2'd0,
        PH_WR  = 2'd1,
        PH_RD  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [2:0]          bit_cnt;
        logic [BYTE_W-1:0]   rx_sh;
        logic [ADDR_W-1:0]   addr;
        logic [BYTE_W-1:0]   tx_sh;
        logic                tx_loaded;
        logic                miso;
        logic                irq_arm;
        logic                irq;
        logic                busy;
        logic                sclk_prev;
    } eng_s;

endpackage

// File: rtl/spi_cp_sync.sv
module spi_cp_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spi_cp_fifo.sv
module spi_cp_fifo #(
    parameter  int WIDTH = 8,
    parameter  int DEPTH = 8,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [LW-1:0]    level
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
    logic [LW-1:0]    cnt_q, cnt_d;
    logic             do_push, do_pop;

    always_comb begin
        wr_d    = wr_q;
        rd_d    = rd_q;
        do_push = push && (cnt_q != LW'(DEPTH));
        do_pop  = pop && (cnt_q != '0);
        if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
        if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
        cnt_d = cnt_q + LW'(do_push) - LW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_d;
            rd_q  <= rd_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= wdata;
    end

    assign head  = mem_q[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == LW'(DEPTH));
    assign level = cnt_q;
endmodule

// File: rtl/spi_cp_regfile.sv
module spi_cp_regfile #(
    parameter  int NUM_REGS = 8,
    parameter  int WIDTH    = 8,
    localparam int IW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IW-1:0]    widx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IW-1:0]    rsel,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] reg_q [NUM_REGS];
    logic [WIDTH-1:0] reg_d [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_comb begin
                reg_d[g] = reg_q[g];
                if (we && (widx == IW'(g))) reg_d[g] = wdata;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) reg_q[g] <= '0;
                else        reg_q[g] <= reg_d[g];
            end
        end
    endgenerate

    assign rdata = reg_q[rsel];
endmodule

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port
    import spi_cp_pkg::*;
#(
    parameter  int                IN_DEPTH      = 8,
    parameter  int                OUT_DEPTH     = 8,
    parameter  int                NUM_REGS      = 8,
    parameter  logic [ADDR_W-1:0] DATA_ADDR     = 7'h20,
    parameter  int                BUSY_ON_FREE  = 2,
    parameter  int                BUSY_OFF_FREE = 4,
    parameter  int                SYNC_STAGES   = 2,
    localparam int                REG_AW        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int                IN_LW         = $clog2(IN_DEPTH + 1),
    localparam int                OUT_LW        = $clog2(OUT_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              busy_n,
    output logic              irq_n,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_full,
    input  logic [REG_AW-1:0] reg_sel,
    output logic [BYTE_W-1:0] reg_value
);
    localparam logic [IN_LW-1:0] BUSY_SET_LVL = IN_LW'(IN_DEPTH - BUSY_ON_FREE);
    localparam logic [IN_LW-1:0] BUSY_CLR_LVL = IN_LW'(IN_DEPTH - BUSY_OFF_FREE);

    logic [2:0]        pin_s;
    logic              sclk_s, cs_n_s, mosi_s;
    logic              sclk_rise, sclk_fall, rd_fall;
    logic              rx_push, rx_empty, rx_full, reg_we, tx_pop, tx_empty;
    logic [IN_LW-1:0]  rx_level;
    logic [OUT_LW-1:0] tx_level;
    logic [BYTE_W-1:0] tx_head, sh_nxt;
    eng_s              q, d;

    spi_cp_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_sclk, spi_cs_n, spi_mosi}),
        .dout (pin_s)
    );

    assign {sclk_s, cs_n_s, mosi_s} = pin_s;
    assign sclk_rise = sclk_s & ~q.sclk_prev;
    assign sclk_fall = ~sclk_s & q.sclk_prev;
    assign rd_fall   = sclk_fall & ~cs_n_s & (q.phase == PH_RD);
    assign sh_nxt    = {q.rx_sh[BYTE_W-2:0], mosi_s};

    always_comb begin
        d           = q;
        rx_push     = 1'b0;
        reg_we      = 1'b0;
        tx_pop      = 1'b0;
        d.sclk_prev = sclk_s;

        if (cs_n_s) begin
            d.phase     = PH_HDR;
            d.bit_cnt   = '0;
            d.tx_loaded = 1'b0;
            d.irq_arm   = 1'b1;
        end else if (sclk_rise) begin
            d.rx_sh   = sh_nxt;
            d.bit_cnt = q.bit_cnt + 3'd1;
            if ((q.phase == PH_RD) && (q.bit_cnt == 3'd0) && q.tx_loaded) begin
                tx_pop      = 1'b1;
                d.tx_loaded = 1'b0;
            end
            if (q.bit_cnt == 3'd7) begin
                case (q.phase)
                    PH_HDR: begin
                        d.addr  = sh_nxt[BYTE_W-1:1];
                        d.phase = sh_nxt[0] ? PH_RD : PH_WR;
                    end
                    PH_WR: begin
                        if (q.addr == DATA_ADDR) rx_push = 1'b1;
                        else                     reg_we  = 1'b1;
                    end
                    default: ;
                endcase
            end
        end else if (rd_fall) begin
            d.irq_arm = 1'b0;
            if (q.bit_cnt == 3'd0) begin
                d.tx_sh     = tx_empty ? '0 : tx_head;
                d.tx_loaded = ~tx_empty;
                d.miso      = tx_empty ? 1'b0 : tx_head[BYTE_W-1];
            end else begin
                d.miso = q.tx_sh[3'd7 - q.bit_cnt];
            end
        end

        if (rx_level >= BUSY_SET_LVL)      d.busy = 1'b1;
        else if (rx_level <= BUSY_CLR_LVL) d.busy = 1'b0;

        d.irq = d.irq_arm & ~tx_empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.phase   <= PH_HDR;
            q.irq_arm <= 1'b1;
        end else begin
            q <= d;
        end
    end

    spi_cp_fifo #(
        .WIDTH(BYTE_W),
        .DEPTH(IN_DEPTH)
    ) u_rx_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (rx_push),
        .wdata(sh_nxt),
        .pop  (rx_pop),
        .head (rx_data),
        .empty(rx_empty),
        .full (rx_full),
        .level(rx_level)
    );

    spi_cp_fifo #(
        .WIDTH(BYTE_W),
        .DEPTH(OUT_DEPTH)
    ) u_tx_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (tx_push),
        .wdata(tx_data),
        .pop  (tx_pop),
        .head (tx_head),
        .empty(tx_empty),
        .full (tx_full),
        .level(tx_level)
    );

    spi_cp_regfile #(
        .NUM_REGS(NUM_REGS),
        .WIDTH   (BYTE_W)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (reg_we),
        .widx (q.addr[REG_AW-1:0]),
        .wdata(sh_nxt),
        .rsel (reg_sel),
        .rdata(reg_value)
    );

    assign rx_valid    = ~rx_empty;
    assign spi_miso    = q.miso;
    assign spi_miso_oe = ~cs_n_s;
    assign busy_n      = ~q.busy;
    assign irq_n       = ~q.irq;
endmodule

// File: rtl/spi_ctrl_port_chk.sv
module spi_ctrl_port_chk #(
    parameter  int IN_DEPTH      = 8,
    parameter  int BUSY_ON_FREE  = 2,
    parameter  int BUSY_OFF_FREE = 4,
    localparam int IN_LW         = $clog2(IN_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spi_cs_n,
    input logic             spi_miso_oe,
    input logic             busy_n,
    input logic             irq_n,
    input logic [IN_LW-1:0] rx_level,
    input logic             rx_push,
    input logic             rx_full,
    input logic             rx_pop,
    input logic             tx_pop,
    input logic             tx_empty,
    input logic             rd_fall
);
    // R5
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= IN_LW'(IN_DEPTH - BUSY_ON_FREE)) |=> !busy_n);

    // R5
    busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= IN_LW'(IN_DEPTH - BUSY_OFF_FREE)) |=> busy_n);

    // R6
    rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_pop) |=> (rx_level == $past(rx_level)));

    // R7
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fall |=> irq_n);

    // R7
    irq_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> !$past(tx_empty));

    // R10
    tx_pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    // R9
    miso_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe);
endmodule

bind spi_ctrl_port spi_ctrl_port_chk #(
    .IN_DEPTH     (IN_DEPTH),
    .BUSY_ON_FREE (BUSY_ON_FREE),
    .BUSY_OFF_FREE(BUSY_OFF_FREE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .spi_miso_oe(spi_miso_oe),
    .busy_n     (busy_n),
    .irq_n      (irq_n),
    .rx_level   (rx_level),
    .rx_push    (rx_push),
    .rx_full    (rx_full),
    .rx_pop     (rx_pop),
    .tx_pop     (tx_pop),
    .tx_empty   (tx_empty),
    .rd_fall    (rd_fall)
);

// File: tb/tb_spi_ctrl_port.sv
module tb_spi_ctrl_port;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso, spi_miso_oe, busy_n, irq_n;
    logic       rx_pop, rx_valid, tx_push = 1'b0, tx_full;
    logic [7:0] rx_data, tx_data = 8'h00, reg_value;
    logic [2:0] reg_sel = 3'd0;

    int checks = 0;
    int errors = 0;
    bit drain_en = 1'b1;
    int pop_req = 0;
    int pops_done = 0;
    logic [7:0] exp_rx[$];

    always #10 clk = ~clk;

    spi_ctrl_port dut (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .busy_n(busy_n), .irq_n(irq_n),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
        .reg_sel(reg_sel), .reg_value(reg_value)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the input FIFO and compares against the scoreboard queue (R2, R6)
    initial begin
        rx_pop = 1'b0;
        forever begin
            @(negedge clk);
            rx_pop = 1'b0;
            if (rst_n && rx_valid && (drain_en || pops_done < pop_req)) begin
                if (exp_rx.size() == 0) chk("R2 unexpected byte", rx_data, 32'hFFFF_FFFF);
                else                    chk("R2", rx_data, exp_rx.pop_front());
                rx_pop = 1'b1;
                if (!drain_en) pops_done++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, input int nbits = 8);
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic cs_on();
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic tx_write(input logic [7:0] b);
        tx_data = b;
        tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    initial begin
        logic [7:0] r;
        int cnt;
        bit busy_m;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9 reset state
        chk("R9 busy_n", busy_n, 1);
        chk("R9 irq_n", irq_n, 1);
        chk("R9 rx_valid", rx_valid, 0);
        chk("R9 miso_oe", spi_miso_oe, 0);
        chk("R9 reg0", reg_value, 0);

        // R1 R2: write header {0x20, 0} then three data-port bytes
        cs_on();
        chk("R9 miso_oe active", spi_miso_oe, 1);
        spi_byte({7'h20, 1'b0}, r);
        exp_rx.push_back(8'hA5); spi_byte(8'hA5, r);
        exp_rx.push_back(8'h3C); spi_byte(8'h3C, r);
        exp_rx.push_back(8'h0F); spi_byte(8'h0F, r);
        cs_off();
        repeat (20) @(negedge clk);
        chk("R2 all bytes drained", exp_rx.size(), 0);

        // R3: register write to address 0x03, last byte stays
        cs_on();
        spi_byte({7'h03, 1'b0}, r);
        spi_byte(8'h5A, r);
        spi_byte(8'h77, r);
        cs_off();
        reg_sel = 3'd3;
        @(negedge clk);
        chk("R3 reg3", reg_value, 8'h77);
        chk("R3 fifo untouched", rx_valid, 0);

        // R7 R4: output FIFO read
        tx_write(8'h81);
        tx_write(8'hC3);
        repeat (3) @(negedge clk);
        chk("R7 irq asserted", irq_n, 0);
        cs_on();
        spi_byte({7'h10, 1'b1}, r);
        spi_byte(8'h00, r);
        chk("R4 byte0", r, 8'h81);
        chk("R7 irq released in read", irq_n, 1);
        spi_byte(8'h00, r);
        chk("R4 byte1", r, 8'hC3);
        spi_byte(8'h00, r);
        chk("R4 empty byte", r, 8'h00);
        cs_off();
        chk("R9 miso_oe idle", spi_miso_oe, 0);
        chk("R7 irq stays high when empty", irq_n, 1);

        // R10: header-only read leaves preloaded byte in FIFO
        tx_write(8'h66);
        repeat (3) @(negedge clk);
        cs_on();
        spi_byte({7'h10, 1'b1}, r);
        cs_off();
        chk("R10 irq rearmed", irq_n, 0);
        cs_on();
        spi_byte({7'h10, 1'b1}, r);
        spi_byte(8'h00, r);
        chk("R10 byte kept", r, 8'h66);
        cs_off();
        chk("R7 irq after drain", irq_n, 1);

        // R8: partial data byte then partial header are discarded
        cs_on();
        spi_byte({7'h20, 1'b0}, r);
        spi_byte(8'hF0, r, 4);
        cs_off();
        cs_on();
        spi_byte(8'hE3, r, 5);
        cs_off();
        cs_on();
        spi_byte({7'h05, 1'b0}, r);
        spi_byte(8'h42, r);
        cs_off();
        reg_sel = 3'd5;
        @(negedge clk);
        chk("R8 reg5 after partials", reg_value, 8'h42);
        chk("R8 no partial push", rx_valid, 0);
        cs_on();
        spi_byte({7'h20, 1'b0}, r);
        exp_rx.push_back(8'h99); spi_byte(8'h99, r);
        cs_off();
        repeat (20) @(negedge clk);
        chk("R8 only full byte", exp_rx.size(), 0);

        // R5 R6: fill with draining stopped
        drain_en = 1'b0;
        repeat (4) @(negedge clk);
        cnt = 0;
        busy_m = 1'b0;
        cs_on();
        spi_byte({7'h20, 1'b0}, r);
        for (int k = 0; k < 10; k++) begin
            if (k < 8) exp_rx.push_back(8'h10 + 8'(k));
            spi_byte(8'h10 + 8'(k), r);
            if (cnt < 8) cnt++;
            if (cnt >= 6)      busy_m = 1'b1;
            else if (cnt <= 4) busy_m = 1'b0;
            chk("R5 busy during fill", busy_n, !busy_m);
        end
        cs_off();
        pop_req += 3;
        repeat (20) @(negedge clk);
        chk("R5 busy held at 3 free", busy_n, 0);
        pop_req += 1;
        repeat (20) @(negedge clk);
        chk("R5 busy released at 4 free", busy_n, 1);
        drain_en = 1'b1;
        repeat (40) @(negedge clk);
        chk("R6 extra bytes dropped", exp_rx.size(), 0);
        chk("R6 fifo empty", rx_valid, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule